// File: doc/BRIEF.md
# Word-Addressed 32-bit Processor Core

This block is a small, non-pipelined processor core for a 32-bit machine. Memory is addressed in whole words. The core has sixteen general registers and eleven instructions: register add, register NAND, add-immediate, load, store, an unconditional relative branch, two register-compare branches, a jump that links through a register, a PC-relative address load, and halt. Each instruction is fetched from an instruction port that is read combinationally at the current PC. It is then decoded, executed and written back, and the PC is updated. Most instructions take one cycle. A load takes two, because the data memory returns its word one clock after the address.

The core is meant to sit next to two memories that can be mapped to block RAM: a read-only instruction store and a data store with one read/write port. Execution runs from reset until a halt instruction. After that the `done_o` output stays high and the core fetches and commits nothing more until the next reset.

Top module: `wac_core`

## Requirements
- R1: Field layout: opcode in [31:28], destination/store-source/link register in [27:24], first source/base/jump register in [23:20], second register source in [3:0], 20-bit immediate in [19:0]. ADD (0000) and ADDI (0010, immediate sign-extended) wrap modulo 2^32.
- R2: NAND (0001) writes the bitwise complement of the AND of its two sources.
- R3: Register 0 always reads as zero, and any write to it is discarded.
- R4: LW (0011) and SW (0100) use the address base register plus the sign-extended immediate, cut to the low 16 bits. SW drives the register named in [27:24] as write data and asserts the write enable for exactly one cycle. The data port has a one-cycle read latency.
- R5: BLT (1000) and BGT (1001) compare register [27:24] against register [23:20] as signed numbers. When the comparison holds, the branch goes to PC+1+sext(imm); otherwise execution falls through to PC+1.
- R6: BR (0101) always goes to PC+1+sext(imm).
- R7: JALR (0110) writes PC+1 into register [27:24] and jumps to the value that register [23:20] held before the write, including when both fields name the same register.
- R8: LEA (1010) writes PC+1+sext(imm) into register [27:24].
- R9: After HALT (0111), `done_o` is high, the PC no longer changes, and no store is issued until reset.
- R10: Synchronous reset sets the PC to 0, clears `done_o` and sets every register to zero.
- R11: Opcodes 1011 to 1111 change no register and no memory, and only advance the PC by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iaddr_o | output | 16 | Instruction word address (the PC) |
| idata_i | input | 32 | Instruction word at `iaddr_o`, combinational |
| daddr_o | output | 16 | Data word address |
| dwdata_o | output | 32 | Store data |
| dwe_o | output | 1 | Store enable |
| drdata_i | input | 32 | Load data, one cycle after the address |
| done_o | output | 1 | High once HALT has executed |

## Verification
The results of a single straight-line program are observed through the stores it issues. Each store is matched, in order, against an expected address and value computed from the requirements. The operand values are chosen to separate the likely faults:
- A negative operand against a positive one tells a signed comparison from an unsigned one.
- An immediate of minus one followed by plus two exposes a missing wrap.
- A base of 0x10000 checks that addresses are cut to 16 bits.
- A jump whose link register is also its target register shows whether the jump uses the old value of that register.

Placing stores on skipped paths, after the undefined opcode and after HALT turns any wrong branch, unwanted write or missing stop into an extra or misplaced store.

// File: rtl/wac_pkg.sv
package wac_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'b0000, OP_NAND = 4'b0001, OP_ADDI = 4'b0010, OP_LW   = 4'b0011,
    OP_SW   = 4'b0100, OP_BR   = 4'b0101, OP_JALR = 4'b0110, OP_HALT = 4'b0111,
    OP_BLT  = 4'b1000, OP_BGT  = 4'b1001, OP_LEA  = 4'b1010
  } op_e;

  typedef enum logic [2:0] {
    RES_ADD, RES_NAND, RES_ADDI, RES_LEA, RES_LINK
  } res_e;

  typedef enum logic [2:0] {
    FLOW_SEQ, FLOW_REL, FLOW_LT, FLOW_GT, FLOW_REG
  } flow_e;

  typedef struct packed {
    logic  wr_reg;
    logic  load;
    logic  store;
    logic  halt;
    logic  b_low;
    res_e  res;
    flow_e flow;
  } ctrl_t;
endpackage

// File: rtl/wac_decode.sv
module wac_decode
  import wac_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] instr,
  output ctrl_t         ctrl
);
  logic [3:0] opc;
  assign opc = instr[DW-1 -: 4];

  always_comb begin
    ctrl = '{wr_reg: 1'b0, load: 1'b0, store: 1'b0, halt: 1'b0,
             b_low: 1'b0, res: RES_ADD, flow: FLOW_SEQ};
    case (opc)
      OP_ADD:  begin ctrl.wr_reg = 1'b1; ctrl.b_low = 1'b1; ctrl.res = RES_ADD;  end
      OP_NAND: begin ctrl.wr_reg = 1'b1; ctrl.b_low = 1'b1; ctrl.res = RES_NAND; end
      OP_ADDI: begin ctrl.wr_reg = 1'b1; ctrl.res = RES_ADDI; end
      OP_LW:   ctrl.load  = 1'b1;
      OP_SW:   ctrl.store = 1'b1;
      OP_BR:   ctrl.flow  = FLOW_REL;
      OP_JALR: begin ctrl.wr_reg = 1'b1; ctrl.res = RES_LINK; ctrl.flow = FLOW_REG; end
      OP_HALT: ctrl.halt  = 1'b1;
      OP_BLT:  ctrl.flow  = FLOW_LT;
      OP_BGT:  ctrl.flow  = FLOW_GT;
      OP_LEA:  begin ctrl.wr_reg = 1'b1; ctrl.res = RES_LEA; end
      default: ;
    endcase
  end
endmodule

// File: rtl/wac_regfile.sv
module wac_regfile #(
  parameter int DW   = 32,
  parameter int NREG = 16,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [IW-1:0] ra_idx,
  input  logic [IW-1:0] rb_idx,
  output logic [DW-1:0] ra_val,
  output logic [DW-1:0] rb_val,
  input  logic          w_en,
  input  logic [IW-1:0] w_idx,
  input  logic [DW-1:0] w_val
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (w_en && w_idx != '0) begin
      regs[w_idx] <= w_val;
    end
  end

  assign ra_val = (ra_idx == '0) ? '0 : regs[ra_idx];
  assign rb_val = (rb_idx == '0) ? '0 : regs[rb_idx];
endmodule

// File: rtl/wac_exec.sv
module wac_exec
  import wac_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 16,
  parameter int IMMW = 20
) (
  input  ctrl_t         ctrl,
  input  logic [DW-1:0] instr,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] a_val,
  input  logic [DW-1:0] b_val,
  output logic [DW-1:0] result,
  output logic [AW-1:0] next_pc,
  output logic [AW-1:0] mem_addr
);
  logic [DW-1:0] imm_x, pc_inc, rel_tgt, sum_mem;
  logic          take;

  assign imm_x   = {{(DW-IMMW){instr[IMMW-1]}}, instr[IMMW-1:0]};
  assign pc_inc  = {{(DW-AW){1'b0}}, pc} + DW'(1);
  assign rel_tgt = pc_inc + imm_x;
  assign sum_mem = a_val + imm_x;
  assign mem_addr = sum_mem[AW-1:0];

  always_comb begin
    case (ctrl.res)
      RES_NAND: result = ~(a_val & b_val);
      RES_ADDI: result = a_val + imm_x;
      RES_LEA:  result = rel_tgt;
      RES_LINK: result = pc_inc;
      default:  result = a_val + b_val;
    endcase
  end

  always_comb begin
    case (ctrl.flow)
      FLOW_REL: take = 1'b1;
      FLOW_LT:  take = $signed(b_val) < $signed(a_val);
      FLOW_GT:  take = $signed(b_val) > $signed(a_val);
      default:  take = 1'b0;
    endcase
    if (ctrl.flow == FLOW_REG) next_pc = a_val[AW-1:0];
    else if (take)             next_pc = rel_tgt[AW-1:0];
    else                       next_pc = pc_inc[AW-1:0];
  end
endmodule

// File: rtl/wac_core.sv
module wac_core
  import wac_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 16,
  parameter int NREG = 16
) (
  input  logic          clk,
  input  logic          rst,
  output logic [AW-1:0] iaddr_o,
  input  logic [DW-1:0] idata_i,
  output logic [AW-1:0] daddr_o,
  output logic [DW-1:0] dwdata_o,
  output logic          dwe_o,
  input  logic [DW-1:0] drdata_i,
  output logic          done_o
);
  localparam int IW = $clog2(NREG);

  logic [AW-1:0] pc_q, nxt_pc;
  logic          done_q, ld_wait_q;
  ctrl_t         ctrl;
  logic [IW-1:0] ra_idx, rb_idx, rd_idx;
  logic [DW-1:0] a_val, b_val, res_val, w_val;
  logic          w_en, live;

  assign live   = !done_q && !ld_wait_q;
  assign ra_idx = idata_i[23:20];
  assign rd_idx = idata_i[27:24];
  assign rb_idx = ctrl.b_low ? idata_i[3:0] : idata_i[27:24];

  wac_decode #(.DW(DW)) u_dec (.instr(idata_i), .ctrl(ctrl));

  wac_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst(rst),
    .ra_idx(ra_idx), .rb_idx(rb_idx), .ra_val(a_val), .rb_val(b_val),
    .w_en(w_en), .w_idx(rd_idx), .w_val(w_val)
  );

  wac_exec #(.DW(DW), .AW(AW)) u_ex (
    .ctrl(ctrl), .instr(idata_i), .pc(pc_q), .a_val(a_val), .b_val(b_val),
    .result(res_val), .next_pc(nxt_pc), .mem_addr(daddr_o)
  );

  assign w_en  = ld_wait_q || (live && ctrl.wr_reg);
  assign w_val = ld_wait_q ? drdata_i : res_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      done_q    <= 1'b0;
      ld_wait_q <= 1'b0;
    end else if (ld_wait_q) begin
      ld_wait_q <= 1'b0;
      pc_q      <= pc_q + AW'(1);
    end else if (!done_q) begin
      if (ctrl.halt)      done_q    <= 1'b1;
      else if (ctrl.load) ld_wait_q <= 1'b1;
      else                pc_q      <= nxt_pc;
    end
  end

  assign iaddr_o  = pc_q;
  assign dwdata_o = b_val;
  assign dwe_o    = live && ctrl.store;
  assign done_o   = done_q;
endmodule

// File: rtl/wac_core_chk.sv
module wac_core_chk #(
  parameter int DW = 32,
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] iaddr_o,
  input logic [DW-1:0] idata_i,
  input logic [DW-1:0] dwdata_o,
  input logic          dwe_o,
  input logic          done_o
);
  AST_HALT_HOLDS: assert property (@(posedge clk) disable iff (rst)
    done_o |=> (done_o && $stable(iaddr_o))); // R9
  AST_NO_STORE_AFTER_HALT: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !dwe_o); // R9
  AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (rst)
    dwe_o |-> (idata_i[31:28] == 4'b0100)); // R4
  AST_STORE_ADVANCES: assert property (@(posedge clk) disable iff (rst)
    dwe_o |=> (iaddr_o == $past(iaddr_o) + AW'(1))); // R4
  AST_ZERO_REG_DATA: assert property (@(posedge clk) disable iff (rst)
    (dwe_o && idata_i[27:24] == 4'd0) |-> (dwdata_o == '0)); // R3
  AST_SPARE_OPCODE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!done_o && idata_i[31:28] >= 4'hB) |=> (iaddr_o == $past(iaddr_o) + AW'(1))); // R11
endmodule

bind wac_core wac_core_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .iaddr_o(iaddr_o), .idata_i(idata_i),
  .dwdata_o(dwdata_o), .dwe_o(dwe_o), .done_o(done_o)
);

// File: tb/wac_core_bench.sv
module wac_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] iaddr_o, daddr_o;
  logic [DW-1:0] idata_i, dwdata_o, drdata_i;
  logic          dwe_o, done_o;

  logic [DW-1:0] imem [64];
  logic [DW-1:0] dmem [64];
  logic [47:0]   expq [$];
  int            n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wac_core u_wac_core (
    .clk(clk), .rst(rst), .iaddr_o(iaddr_o), .idata_i(idata_i),
    .daddr_o(daddr_o), .dwdata_o(dwdata_o), .dwe_o(dwe_o),
    .drdata_i(drdata_i), .done_o(done_o)
  );

  assign idata_i = imem[iaddr_o[5:0]];
  always @(posedge clk) begin
    if (!rst && dwe_o) dmem[daddr_o[5:0]] <= dwdata_o;
    drdata_i <= dmem[daddr_o[5:0]];
  end

  function automatic logic [31:0] ri(input logic [3:0] op, input logic [3:0] d,
                                     input logic [3:0] s, input int imm);
    return {op, d, s, imm[19:0]};
  endfunction
  function automatic logic [31:0] rr(input logic [3:0] op, input logic [3:0] d,
                                     input logic [3:0] s1, input logic [3:0] s2);
    return {op, d, s1, 16'h0, s2};
  endfunction

  task automatic check(input bit ok, input string req, input logic [47:0] act,
                       input logic [47:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic expect_store(input logic [15:0] a, input logic [31:0] d);
    expq.push_back({a, d});
  endtask

  // Monitor: every store is matched, in order, against the scoreboard
  always @(negedge clk) begin
    if (!rst && dwe_o) begin
      if (expq.size() == 0) check(1'b0, "R9/R5 extra store", {daddr_o, dwdata_o}, '0);
      else begin
        logic [47:0] e;
        e = expq.pop_front();
        check({daddr_o, dwdata_o} == e, "store R1-R11 item", {daddr_o, dwdata_o}, e);
      end
    end
  end

  initial begin
    for (int i = 0; i < 64; i++) begin imem[i] = 32'hB000_0000; dmem[i] = '0; end
    imem[0]  = ri(4'h4, 4'd5, 4'd0, 'h10);  expect_store(16'h10, 32'h0);        // R10 regs zero
    imem[1]  = ri(4'h2, 4'd1, 4'd0, 5);
    imem[2]  = ri(4'h2, 4'd2, 4'd0, -3);
    imem[3]  = rr(4'h0, 4'd3, 4'd1, 4'd2);
    imem[4]  = ri(4'h4, 4'd3, 4'd0, 'h11);  expect_store(16'h11, 32'd2);        // R1 add
    imem[5]  = rr(4'h1, 4'd4, 4'd1, 4'd2);
    imem[6]  = ri(4'h4, 4'd4, 4'd0, 'h12);  expect_store(16'h12, 32'hFFFFFFFA); // R2 nand
    imem[7]  = ri(4'h2, 4'd0, 4'd1, 7);
    imem[8]  = ri(4'h4, 4'd0, 4'd0, 'h13);  expect_store(16'h13, 32'h0);        // R3
    imem[9]  = ri(4'h2, 4'd6, 4'd0, -1);
    imem[10] = ri(4'h2, 4'd6, 4'd6, 2);
    imem[11] = ri(4'h4, 4'd6, 4'd0, 'h14);  expect_store(16'h14, 32'd1);        // R1 wrap
    imem[12] = ri(4'h3, 4'd7, 4'd0, 'h12);
    imem[13] = ri(4'h4, 4'd7, 4'd0, 'h15);  expect_store(16'h15, 32'hFFFFFFFA); // R4 load
    imem[14] = ri(4'h2, 4'd8, 4'd0, 'h10000);
    imem[15] = ri(4'h4, 4'd1, 4'd8, 'h16);  expect_store(16'h16, 32'd5);        // R4 truncation
    imem[16] = ri(4'h2, 4'd9, 4'd0, 'h20);
    imem[17] = ri(4'h4, 4'd3, 4'd9, -8);    expect_store(16'h18, 32'd2);        // R4 negative offset
    imem[18] = ri(4'h8, 4'd2, 4'd1, 1);                                         // R5 BLT taken
    imem[19] = ri(4'h4, 4'd1, 4'd0, 'h1F);
    imem[20] = ri(4'h9, 4'd2, 4'd1, 1);                                         // R5 BGT not taken
    imem[21] = ri(4'h4, 4'd1, 4'd0, 'h19);  expect_store(16'h19, 32'd5);
    imem[22] = ri(4'h5, 4'd0, 4'd0, 1);                                         // R6
    imem[23] = ri(4'h4, 4'd1, 4'd0, 'h1F);
    imem[24] = ri(4'h4, 4'd3, 4'd0, 'h1A);  expect_store(16'h1A, 32'd2);
    imem[25] = ri(4'hA, 4'd10, 4'd0, -5);
    imem[26] = ri(4'h4, 4'd10, 4'd0, 'h1B); expect_store(16'h1B, 32'd21);       // R8
    imem[27] = ri(4'h2, 4'd11, 4'd0, 31);
    imem[28] = ri(4'h6, 4'd15, 4'd11, 0);
    imem[29] = ri(4'h4, 4'd1, 4'd0, 'h1F);
    imem[30] = ri(4'h4, 4'd1, 4'd0, 'h1F);
    imem[31] = ri(4'h4, 4'd15, 4'd0, 'h1C); expect_store(16'h1C, 32'd29);       // R7 link
    imem[32] = ri(4'h2, 4'd12, 4'd0, 36);
    imem[33] = ri(4'h6, 4'd12, 4'd12, 0);
    imem[34] = ri(4'h4, 4'd1, 4'd0, 'h1F);
    imem[35] = ri(4'h4, 4'd1, 4'd0, 'h1F);
    imem[36] = ri(4'h4, 4'd12, 4'd0, 'h1D); expect_store(16'h1D, 32'd34);       // R7 same register
    imem[37] = 32'hB110_0005;                                                   // R11 spare opcode
    imem[38] = ri(4'h4, 4'd1, 4'd0, 'h1E);  expect_store(16'h1E, 32'd5);
    imem[39] = 32'h7000_0000;                                                   // R9 halt
    imem[40] = ri(4'h4, 4'd1, 4'd0, 'h1F);

    repeat (3) @(posedge clk);
    @(negedge clk);
    check(iaddr_o == 16'd0, "R10 pc", {32'h0, iaddr_o}, 48'h0);
    check(done_o == 1'b0, "R10 done", {47'h0, done_o}, 48'h0);
    rst = 1'b0;

    begin
      int cyc = 0;
      while (!done_o && cyc < 2000) begin @(negedge clk); cyc++; end
      if (!done_o) check(1'b0, "watchdog", {47'h0, done_o}, 48'h1);
    end
    repeat (5) @(negedge clk);
    check(done_o == 1'b1, "R9 done held", {47'h0, done_o}, 48'h1);
    check(iaddr_o == 16'd39, "R9 pc frozen", {32'h0, iaddr_o}, 48'd39);
    check(expq.size() == 0, "R9 all stores seen", 48'(expq.size()), 48'h0);
    check(dmem[6'h1F] == 32'h0, "R5 R6 R9 no stray store", {16'h0, dmem[6'h1F]}, 48'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule